// File: doc/BRIEF.md
# Retention-Binned Row Refresh Scheduler

This block sits in a memory controller and decides, row by row, whether a DRAM row needs a refresh in the current base window. Each `tick` selects the next row from a row pointer that sweeps every row once per base window and wraps. The selected row is tested against two retention bins. A short-retention row is refreshed in every window. A medium-retention row is refreshed in every second window. Every other row is refreshed in every fourth window. A small period counter advances at each wrap of the row pointer and supplies the window phase.

Each bin is a Bloom filter: a 16-bit array indexed by three XOR-fold hashes of the row address. Software or a profiling engine programs the bins through a clear/insert port. A membership test can report a row that was never inserted (that row is then refreshed more often than it needs), but it never misses a row that was inserted.

A high-temperature input halves every effective period. When a refresh is due, the block issues a one-cycle request carrying the row address. It then holds the row pointer until the request is acknowledged.

Top module: `retention_refresh_sched`

## Requirements
- R1: After reset `req_valid` is 0, the row pointer is 0, the period counter is 0 and both bins are empty, so the first window refreshes every row in ascending order.
- R2: A tick accepted while no request is pending evaluates the row at the row pointer and then advances the pointer by one, wrapping from 2**ROW_W-1 to 0. If that row is due, `req_valid` is high for exactly the one cycle after the tick, and `req_row` equals the evaluated row.
- R3: A row that tests present in the short bin (`bin_sel`=0) is due in every window, whatever the period counter holds.
- R4: A row absent from the short bin but present in the medium bin (`bin_sel`=1) is due only when bit 0 of the period counter is 0. The short bin is tested first.
- R5: A row absent from both bins is due only when the period counter is 0.
- R6: With `temp_hot` low, each wrap of the row pointer increments the 2-bit period counter modulo 4.
- R7: An insert sets three array bits at indices h0=lo^hi, h1=lo^{hi[2:0],hi[3]} and h2=lo^{hi[1:0],hi[3:2]}, where lo and hi are row bits [3:0] and [7:4]. A row tests present when all three of its bits are set. An inserted row always tests present, and a row that was never inserted but whose three bits are all set is refreshed as a member.
- R8: A clear zeroes the selected bin in one cycle and wins over an insert in the same cycle. It leaves the other bin untouched.
- R9: A membership test in the same cycle as an insert of that row into that bin sees the contents from before the insert.
- R10: With `temp_hot` high, a wrap sets the period counter to 2 when it is below 2, and to 0 otherwise. Medium rows then become due in every window and other rows in every second window.
- R11: From a request until the first cycle in which `req_ack` is high, ticks are ignored and the row pointer does not move. A tick in the acknowledge cycle itself is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bin_clr | input | 1 | Clear the selected bin |
| bin_ins | input | 1 | Insert `bin_row` into the selected bin |
| bin_sel | input | 1 | Bin select: 0 short retention, 1 medium retention |
| bin_row | input | ROW_W | Row address to insert |
| tick | input | 1 | Evaluate the current row and advance |
| temp_hot | input | 1 | High-temperature rate scaling |
| req_ack | input | 1 | Acknowledge of the pending refresh request |
| req_valid | output | 1 | One-cycle refresh request |
| req_row | output | ROW_W | Row address to refresh |

## Verification
Full sweeps with both bins empty show that the period counter alone gates default rows: only the first of four windows refreshes. Sweeps with a mix of short-bin and medium-bin rows separate the three rates and the test order. Rows whose hash bits collide are included, so false-positive members are checked too. A sweep with `temp_hot` high checks the halved periods. Short directed sequences cover the rest. Repeated ticks with the acknowledge held back show the stall. An insert in the same cycle as the test of that row shows the pre-insert result. A clear together with an insert shows clear priority and that the other bin is kept.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  typedef enum logic [1:0] {
    CLS_SHORT  = 2'd0,
    CLS_MEDIUM = 2'd1,
    CLS_LONG   = 2'd2
  } ret_class_t;

  localparam int unsigned NUM_BINS = 2;
  localparam int unsigned BIN_SHORT = 0;
  localparam int unsigned BIN_MEDIUM = 1;
endpackage

// File: rtl/rrs_hash.sv
module rrs_hash #(
  parameter int unsigned ROW_W    = 8,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned NUM_HASH = 3
) (
  input  logic [ROW_W-1:0]          row,
  output logic [NUM_HASH*IDX_W-1:0] idx
);
  localparam int unsigned CHUNKS = ROW_W / IDX_W;

  // Hash k: XOR of all IDX_W-bit chunks, chunk c rotated left by k*c.
  always_comb begin
    idx = '0;
    for (int k = 0; k < NUM_HASH; k++) begin
      for (int c = 0; c < CHUNKS; c++) begin
        for (int b = 0; b < IDX_W; b++) begin
          idx[k*IDX_W+b] = idx[k*IDX_W+b] ^
            row[c*IDX_W + ((b + IDX_W - ((k*c) % IDX_W)) % IDX_W)];
        end
      end
    end
  end
endmodule

// File: rtl/rrs_bloom_bin.sv
module rrs_bloom_bin #(
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned NUM_HASH = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      ins,
  input  logic [NUM_HASH*IDX_W-1:0] ins_idx,
  input  logic [NUM_HASH*IDX_W-1:0] tst_idx,
  output logic                      hit
);
  localparam int unsigned ARR_N = 1 << IDX_W;

  logic [ARR_N-1:0] arr_q;
  logic [ARR_N-1:0] arr_d;
  logic [ARR_N-1:0] set_mask;
  logic             arr_en;

  always_comb begin
    set_mask = '0;
    hit      = 1'b1;
    for (int k = 0; k < NUM_HASH; k++) begin
      set_mask[ins_idx[k*IDX_W +: IDX_W]] = 1'b1;
      hit = hit & arr_q[tst_idx[k*IDX_W +: IDX_W]];
    end
    arr_en = clr | ins;
    if (clr) begin
      arr_d = '0;
    end else begin
      arr_d = arr_q | set_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_q <= '0;
    end else if (arr_en) begin
      arr_q <= arr_d;
    end
  end
endmodule

// File: rtl/rrs_row_walker.sv
module rrs_row_walker #(
  parameter int unsigned ROW_W = 8,
  parameter int unsigned PER_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             hot,
  output logic [ROW_W-1:0] row_ptr,
  output logic [PER_W-1:0] period_q
);
  localparam logic [ROW_W-1:0] ROW_LAST = '1;

  logic [ROW_W-1:0] row_d;
  logic [PER_W-1:0] period_d;
  logic             wrap;

  always_comb begin
    wrap  = adv && (row_ptr == ROW_LAST);
    row_d = row_ptr + 1'b1;
    if (hot) begin
      period_d = {period_q[PER_W-1:1] + 1'b1, 1'b0};
    end else begin
      period_d = period_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_ptr <= '0;
    end else if (adv) begin
      row_ptr <= row_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
    end else if (wrap) begin
      period_q <= period_d;
    end
  end
endmodule

// File: rtl/retention_refresh_sched.sv
module retention_refresh_sched
  import rrs_pkg::*;
#(
  parameter int unsigned ROW_W    = 8,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned NUM_HASH = 3,
  parameter int unsigned PER_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bin_clr,
  input  logic             bin_ins,
  input  logic             bin_sel,
  input  logic [ROW_W-1:0] bin_row,
  input  logic             tick,
  input  logic             temp_hot,
  input  logic             req_ack,
  output logic             req_valid,
  output logic [ROW_W-1:0] req_row
);
  localparam int unsigned HB = NUM_HASH * IDX_W;

  logic [HB-1:0]       ins_idx;
  logic [HB-1:0]       tst_idx;
  logic [NUM_BINS-1:0] bin_hit;
  logic                short_hit;
  logic                medium_hit;
  logic [ROW_W-1:0]    row_ptr;
  logic [PER_W-1:0]    period_q;
  logic                pend_q;
  logic                pend_d;
  logic                accept;
  logic                due;
  logic                fire;
  ret_class_t          row_class;

  rrs_hash #(.ROW_W(ROW_W), .IDX_W(IDX_W), .NUM_HASH(NUM_HASH)) u_hash_ins (
    .row (bin_row),
    .idx (ins_idx)
  );

  rrs_hash #(.ROW_W(ROW_W), .IDX_W(IDX_W), .NUM_HASH(NUM_HASH)) u_hash_tst (
    .row (row_ptr),
    .idx (tst_idx)
  );

  for (genvar g = 0; g < NUM_BINS; g++) begin : g_bin
    rrs_bloom_bin #(.IDX_W(IDX_W), .NUM_HASH(NUM_HASH)) u_bin (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (bin_clr && (bin_sel == 1'(g))),
      .ins     (bin_ins && (bin_sel == 1'(g))),
      .ins_idx (ins_idx),
      .tst_idx (tst_idx),
      .hit     (bin_hit[g])
    );
  end

  assign short_hit  = bin_hit[BIN_SHORT];
  assign medium_hit = bin_hit[BIN_MEDIUM];

  rrs_row_walker #(.ROW_W(ROW_W), .PER_W(PER_W)) u_walker (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (accept),
    .hot      (temp_hot),
    .row_ptr  (row_ptr),
    .period_q (period_q)
  );

  // Fixed test order: short bin, then medium bin, then default.
  always_comb begin
    if (short_hit) begin
      row_class = CLS_SHORT;
    end else if (medium_hit) begin
      row_class = CLS_MEDIUM;
    end else begin
      row_class = CLS_LONG;
    end
    case (row_class)
      CLS_SHORT:  due = 1'b1;
      CLS_MEDIUM: due = ~period_q[0];
      default:    due = (period_q == '0);
    endcase
    accept = tick && !pend_q;
    fire   = accept && due;
    if (fire) begin
      pend_d = 1'b1;
    end else if (req_ack) begin
      pend_d = 1'b0;
    end else begin
      pend_d = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      req_valid <= 1'b0;
    end else begin
      pend_q    <= pend_d;
      req_valid <= fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_row <= '0;
    end else if (fire) begin
      req_row <= row_ptr;
    end
  end
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker #(
  parameter int unsigned ROW_W = 8,
  parameter int unsigned PER_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             req_valid,
  input logic [ROW_W-1:0] req_row,
  input logic [ROW_W-1:0] row_ptr,
  input logic [PER_W-1:0] period_q,
  input logic             pend_q,
  input logic             short_hit,
  input logic             medium_hit
);
  localparam logic [ROW_W-1:0] ROW_LAST = '1;

  assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

  assert_row_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_row == $past(row_ptr)));

  assert_short_due_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pend_q && short_hit) |=> req_valid);

  assert_medium_due_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pend_q && !short_hit && medium_hit && !period_q[0]) |=> req_valid);

  assert_long_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pend_q && !short_hit && !medium_hit && (period_q != '0)) |=> !req_valid);

  assert_wrap_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pend_q && (row_ptr == ROW_LAST)) |=> (period_q != $past(period_q)));

  assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> ($stable(row_ptr) && !req_valid));
endmodule

bind retention_refresh_sched rrs_checker #(.ROW_W(ROW_W), .PER_W(PER_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .req_valid  (req_valid),
  .req_row    (req_row),
  .row_ptr    (row_ptr),
  .period_q   (period_q),
  .pend_q     (pend_q),
  .short_hit  (short_hit),
  .medium_hit (medium_hit)
);

// File: tb/retention_refresh_sched_bench.sv
module retention_refresh_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bin_clr = 1'b0;
  logic       bin_ins = 1'b0;
  logic       bin_sel = 1'b0;
  logic [7:0] bin_row = '0;
  logic       tick = 1'b0;
  logic       temp_hot = 1'b0;
  logic       req_ack = 1'b0;
  logic       req_valid;
  logic [7:0] req_row;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_short = '0;
  logic [15:0] m_med = '0;
  int m_row = 0;
  int m_per = 0;

  retention_refresh_sched u_retention_refresh_sched (
    .clk(clk), .rst_n(rst_n), .bin_clr(bin_clr), .bin_ins(bin_ins),
    .bin_sel(bin_sel), .bin_row(bin_row), .tick(tick), .temp_hot(temp_hot),
    .req_ack(req_ack), .req_valid(req_valid), .req_row(req_row)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] hsh(int k, logic [7:0] a);
    logic [3:0] lo, hi;
    lo = a[3:0];
    hi = a[7:4];
    case (k)
      0:       return lo ^ hi;
      1:       return lo ^ {hi[2:0], hi[3]};
      default: return lo ^ {hi[1:0], hi[3:2]};
    endcase
  endfunction

  function automatic logic [15:0] mask_of(logic [7:0] a);
    logic [15:0] m = '0;
    for (int k = 0; k < 3; k++) m[hsh(k, a)] = 1'b1;
    return m;
  endfunction

  function automatic bit member(logic [15:0] arr, logic [7:0] a);
    return (arr & mask_of(a)) == mask_of(a);
  endfunction

  function automatic bit due_of(int a);
    if (member(m_short, 8'(a))) return 1'b1;
    if (member(m_med, 8'(a))) return (m_per % 2) == 0;
    return m_per == 0;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_adv();
    if (m_row == NROWS - 1) begin
      m_row = 0;
      if (temp_hot) m_per = (m_per < 2) ? 2 : 0;
      else m_per = (m_per + 1) % 4;
    end else begin
      m_row++;
    end
  endtask

  // One row: tick, check request, acknowledge it.
  task automatic row_step(string req);
    bit exp;
    exp = due_of(m_row);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    chk(req_valid == exp, req, "req_valid", int'(req_valid), int'(exp));
    if (exp && req_valid) chk(req_row == 8'(m_row), req, "req_row", int'(req_row), m_row);
    if (req_valid) begin
      req_ack = 1'b1;
      @(negedge clk) req_ack = 1'b0;
      chk(req_valid == 1'b0, "R2", "pulse width", int'(req_valid), 0);
    end
    model_adv();
  endtask

  task automatic run_windows(int n, string req);
    for (int i = 0; i < n * NROWS; i++) row_step(req);
  endtask

  task automatic bin_op(bit sel, bit clr, bit ins, logic [7:0] a);
    @(negedge clk);
    bin_sel = sel; bin_clr = clr; bin_ins = ins; bin_row = a;
    @(negedge clk);
    bin_clr = 1'b0; bin_ins = 1'b0;
    if (clr) begin
      if (sel) m_med = '0; else m_short = '0;
    end else if (ins) begin
      if (sel) m_med |= mask_of(a); else m_short |= mask_of(a);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_valid == 1'b0, "R1", "req_valid after reset", int'(req_valid), 0);
  endtask

  task automatic t_stall();
    // R11: row 0 fires in window 0, later ticks ignored until acked.
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    chk(req_valid == 1'b1, "R1", "first row request", int'(req_valid), 1);
    chk(req_row == 8'd0, "R1", "first row address", int'(req_row), 0);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    chk(req_valid == 1'b0, "R11", "tick while pending", int'(req_valid), 0);
    @(negedge clk) begin tick = 1'b1; req_ack = 1'b1; end
    @(negedge clk) begin tick = 1'b0; req_ack = 1'b0; end
    chk(req_valid == 1'b0, "R11", "tick in ack cycle", int'(req_valid), 0);
    model_adv();
    row_step("R11");  // must be row 1, proving no advance while stalled
  endtask

  task automatic t_bins();
    bin_op(1'b0, 1'b0, 1'b1, 8'h12);
    bin_op(1'b0, 1'b0, 1'b1, 8'h9C);
    bin_op(1'b1, 1'b0, 1'b1, 8'h35);
    bin_op(1'b1, 1'b0, 1'b1, 8'h70);
    bin_op(1'b1, 1'b0, 1'b1, 8'hE1);
    bin_op(1'b1, 1'b0, 1'b1, 8'h12);  // also medium: short must win (R4 order)
    run_windows(4, "R3/R4/R7");
  endtask

  task automatic t_false_pos();
    int fp;
    fp = -1;
    for (int a = 0; a < NROWS; a++)
      if (fp < 0 && member(m_short, 8'(a)) && a != 8'h12 && a != 8'h9C) fp = a;
    chk(fp >= 0, "R7", "collision row exists", fp, 0);
    if (fp >= 0) begin
      while (!(m_row == fp && m_per != 0)) row_step("R7");
      chk(due_of(fp) == 1'b1, "R7", "model due", 0, 1);
      row_step("R7");
    end
  endtask

  task automatic t_same_cycle();
    int tr;
    tr = -1;
    for (int a = 0; a < NROWS; a++)
      if (tr < 0 && !member(m_short, 8'(a)) && !member(m_med, 8'(a))) tr = a;
    while (!(m_row == tr && m_per == 1)) row_step("R5");
    @(negedge clk) begin
      tick = 1'b1; bin_ins = 1'b1; bin_sel = 1'b0; bin_row = 8'(tr);
    end
    @(negedge clk) begin tick = 1'b0; bin_ins = 1'b0; end
    chk(req_valid == 1'b0, "R9", "pre-insert test", int'(req_valid), 0);
    m_short |= mask_of(8'(tr));
    model_adv();
    while (m_row != tr) row_step("R9");
    chk(m_per == 2, "R9", "phase", m_per, 2);
    row_step("R9");  // now a member, due in period 2
  endtask

  task automatic t_clear();
    bin_op(1'b0, 1'b1, 1'b1, 8'h55);  // clear wins over insert
    run_windows(2, "R8");
  endtask

  task automatic t_hot();
    temp_hot = 1'b1;
    run_windows(4, "R10");
    temp_hot = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_stall();
    run_windows(4, "R5/R6");
    t_bins();
    t_false_pos();
    t_same_cycle();
    t_clear();
    t_hot();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule